// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog whose countdown runs from its own slow clock, separate from the clock of the register bus that controls it. Software drives it only through 16-bit command codes written to a key register. One code starts the countdown. One reloads it. Two more open and close write access to the prescaler and reload registers. After it has started, the watchdog runs until the block is reset. If software stops reloading it, the block raises a one-cycle reset request on the watchdog clock each time the countdown expires.

Configuration values and key commands are written in the bus clock domain. Each one crosses into the watchdog clock domain through its own request/acknowledge handshake. The status register shows, for the prescaler and the reload value separately, that an accepted value is still on its way across. While that flag is set, a further write to the same register is dropped.

Bus-side state machines:
- Lock: `LK_CLOSED`, `LK_OPEN`. The open key moves `LK_CLOSED` to `LK_OPEN`. The close key moves `LK_OPEN` to `LK_CLOSED`.
- Handshake, one per channel: `HS_IDLE`, `HS_REQ`, `HS_DRAIN`.
  - A load moves `HS_IDLE` to `HS_REQ`.
  - The synchronised acknowledge going high moves `HS_REQ` to `HS_DRAIN`.
  - The synchronised acknowledge going low moves `HS_DRAIN` back to `HS_IDLE`.

Watchdog-side state machine: `CORE_IDLE`, `CORE_RUN`, `CORE_FIRE`.
- A start command moves `CORE_IDLE` to `CORE_RUN`.
- An expiring tick with a zero count and no refresh in the same cycle moves `CORE_RUN` or `CORE_FIRE` to `CORE_FIRE`.
- Any other cycle moves `CORE_RUN` or `CORE_FIRE` to `CORE_RUN`.

Top module: `kwdg_top`

## Requirements
- R1: After reset the following hold:
  - the prescaler reads 0;
  - the reload register reads 0xFFF;
  - the status register reads 0;
  - configuration writes are locked;
  - the countdown is stopped, and `wd_reset` stays low.
- R2: The registers are decoded at these byte offsets:
  - key at 0x00, which reads 0;
  - prescaler code at 0x04, in bits [2:0];
  - reload value at 0x08, in bits [11:0];
  - status at 0x0C;
  - window at 0x10, which reads 0 and ignores writes.
- R3: Writing 0x00005555 to the key register opens write access. Writing 0x00000000 closes it. Prescaler and reload writes made while access is closed are ignored.
- R4: An accepted prescaler write sets status bit 0, and an accepted reload write sets status bit 1, both visible in the next bus cycle. Each bit clears by itself once its handshake into the watchdog domain has completed.
- R5: A prescaler or reload write is ignored while that register's status bit is set.
- R6: Writing 0x0000CCCC to the key register starts the countdown. Before that, no pulse appears on `wd_reset`, even when reload keys are written.
- R7: While the block is running without refresh, `wd_reset` pulses every (reload+1)·2^(code+2) watchdog clock cycles. Prescaler code 7 divides by 256, the same as code 6.
- R8: Writing 0x0000AAAA to the key register reloads the countdown from the reload value and restarts the prescale period. If these reloads come often enough, no pulse appears; when they stop, pulses resume.
- R9: Each `wd_reset` pulse lasts exactly one watchdog clock cycle.
- R10: The following have no effect on a running countdown:
  - the close key;
  - a repeated start key;
  - any key value other than the four codes, including values whose upper 16 bits are nonzero.
- R11: Asserting `rst_n` stops the countdown and returns all registers to their R1 values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Register bus clock |
| wd_clk | input | 1 | Free-running watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wd_reset | output | 1 | One watchdog-cycle reset request on expiry |

## Verification
The hardest case to reach from the ports is the one where refresh keys keep the countdown from ever expiring. Every refresh has to land in the slow domain before the count reaches zero, even though each one passes through a pending flag and a two-stage synchroniser. The bench sets a short timeout, issues refreshes at a fixed interval well inside it, and counts pulses over that window. It then stops refreshing and shows that the same setting fires. The dropped write while a busy flag is set is reached by issuing a second write on the very next bus cycle. At that point the first handshake cannot yet have completed.

// File: rtl/kwdg_pkg.sv
package kwdg_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_KEY = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_PSC = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_RLD = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_STS = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_WIN = 5'h10;

    localparam logic [15:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [15:0] KEY_START   = 16'hCCCC;
    localparam logic [15:0] KEY_OPEN    = 16'h5555;
    localparam logic [15:0] KEY_CLOSE   = 16'h0000;

    // command channel bit positions
    localparam int CMD_REFRESH = 0;
    localparam int CMD_START   = 1;
    localparam int CMD_W       = 2;

    typedef enum logic {
        LK_CLOSED,
        LK_OPEN
    } lock_state_t;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_REQ,
        HS_DRAIN
    } hs_state_t;

    typedef enum logic [1:0] {
        CORE_IDLE,
        CORE_RUN,
        CORE_FIRE
    } core_state_t;

    typedef enum logic [2:0] {
        KC_NONE,
        KC_REFRESH,
        KC_START,
        KC_OPEN,
        KC_CLOSE
    } key_cmd_t;

    function automatic key_cmd_t decode_key(input logic [BUS_W-1:0] word);
        key_cmd_t res;
        res = KC_NONE;
        if (word[BUS_W-1:16] == '0) begin
            case (word[15:0])
                KEY_REFRESH: res = KC_REFRESH;
                KEY_START:   res = KC_START;
                KEY_OPEN:    res = KC_OPEN;
                KEY_CLOSE:   res = KC_CLOSE;
                default:     res = KC_NONE;
            endcase
        end
        return res;
    endfunction

endpackage

// File: rtl/kwdg_regs.sv
module kwdg_regs
    import kwdg_pkg::*;
#(
    parameter int PSC_W     = 3,
    parameter int RLD_W     = 12,
    parameter int RLD_RESET = 4095
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              psc_busy,
    input  logic              rld_busy,
    input  logic              cmd_busy,
    output logic [PSC_W-1:0]  psc_q,
    output logic [RLD_W-1:0]  rld_q,
    output logic              psc_load,
    output logic              rld_load,
    output logic              cmd_load,
    output logic [CMD_W-1:0]  cmd_data,
    output logic              lock_open
);

    lock_state_t lock_q, lock_d;
    key_cmd_t    key_cmd;
    logic [CMD_W-1:0] pend_q, pend_new;

    always_comb begin
        key_cmd = KC_NONE;
        if (bus_we && bus_addr == OFS_KEY)
            key_cmd = decode_key(bus_wdata);
    end

    // lock state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= LK_CLOSED;
        else        lock_q <= lock_d;
    end

    // lock next state
    always_comb begin
        lock_d = lock_q;
        unique case (lock_q)
            LK_CLOSED: if (key_cmd == KC_OPEN)  lock_d = LK_OPEN;
            LK_OPEN:   if (key_cmd == KC_CLOSE) lock_d = LK_CLOSED;
            default:   lock_d = LK_CLOSED;
        endcase
    end

    // outputs of the lock machine and write qualification
    always_comb begin
        lock_open = (lock_q == LK_OPEN);
        psc_load  = bus_we && bus_addr == OFS_PSC && lock_open && !psc_busy;
        rld_load  = bus_we && bus_addr == OFS_RLD && lock_open && !rld_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q <= '0;
            rld_q <= RLD_W'(RLD_RESET);
        end else begin
            if (psc_load) psc_q <= bus_wdata[PSC_W-1:0];
            if (rld_load) rld_q <= bus_wdata[RLD_W-1:0];
        end
    end

    // commands wait here while the command channel is busy
    always_comb begin
        pend_new = '0;
        pend_new[CMD_REFRESH] = (key_cmd == KC_REFRESH);
        pend_new[CMD_START]   = (key_cmd == KC_START);
        cmd_load = (pend_q != '0) && !cmd_busy;
        cmd_data = pend_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pend_q <= '0;
        else if (cmd_load) pend_q <= pend_new;
        else               pend_q <= pend_q | pend_new;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_PSC: bus_rdata = BUS_W'(psc_q);
            OFS_RLD: bus_rdata = BUS_W'(rld_q);
            OFS_STS: bus_rdata = BUS_W'({rld_busy, psc_busy});
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/kwdg_hs.sv
module kwdg_hs
    import kwdg_pkg::*;
#(
    parameter int W = 1
) (
    input  logic         src_clk,
    input  logic         dst_clk,
    input  logic         rst_n,
    input  logic         src_load,
    input  logic [W-1:0] src_data,
    output logic         src_busy,
    output logic         dst_pulse,
    output logic [W-1:0] dst_data
);

    hs_state_t    hs_q, hs_d;
    logic         req_q;
    logic [W-1:0] data_q;
    logic         ack_s1, ack_s2;
    logic         req_s1, req_s2, ack_q;

    // source state register
    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) hs_q <= HS_IDLE;
        else        hs_q <= hs_d;
    end

    // source next state
    always_comb begin
        hs_d = hs_q;
        unique case (hs_q)
            HS_IDLE:  if (src_load) hs_d = HS_REQ;
            HS_REQ:   if (ack_s2)   hs_d = HS_DRAIN;
            HS_DRAIN: if (!ack_s2)  hs_d = HS_IDLE;
            default:  hs_d = HS_IDLE;
        endcase
    end

    // source outputs: request is a flop so the crossing sees no glitch
    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            data_q <= '0;
            ack_s1 <= 1'b0;
            ack_s2 <= 1'b0;
        end else begin
            req_q  <= (hs_d == HS_REQ);
            ack_s1 <= ack_q;
            ack_s2 <= ack_s1;
            if (hs_q == HS_IDLE && src_load) data_q <= src_data;
        end
    end

    assign src_busy = (hs_q != HS_IDLE);

    // destination side
    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) begin
            req_s1 <= 1'b0;
            req_s2 <= 1'b0;
            ack_q  <= 1'b0;
        end else begin
            req_s1 <= req_q;
            req_s2 <= req_s1;
            ack_q  <= req_s2;
        end
    end

    assign dst_pulse = req_s2 && !ack_q;
    assign dst_data  = data_q;

endmodule

// File: rtl/kwdg_core.sv
module kwdg_core
    import kwdg_pkg::*;
#(
    parameter int PSC_W     = 3,
    parameter int RLD_W     = 12,
    parameter int RLD_RESET = 4095,
    parameter int MAX_CODE  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psc_upd,
    input  logic [PSC_W-1:0] psc_val,
    input  logic             rld_upd,
    input  logic [RLD_W-1:0] rld_val,
    input  logic             cmd_upd,
    input  logic [CMD_W-1:0] cmd_val,
    output logic             wd_reset,
    output logic             running
);

    localparam int DIV_W = MAX_CODE + 2;

    core_state_t      st_q, st_d;
    logic [PSC_W-1:0] psc_s, code_c;
    logic [RLD_W-1:0] rld_s, cnt_q;
    logic [DIV_W-1:0] pdiv_q, div_last;
    logic             do_start, do_refresh, tick, expire;

    always_comb begin
        do_start   = cmd_upd && cmd_val[CMD_START];
        do_refresh = cmd_upd && cmd_val[CMD_REFRESH];
        code_c     = (psc_s > PSC_W'(MAX_CODE)) ? PSC_W'(MAX_CODE) : psc_s;
        div_last   = DIV_W'((1 << (int'(code_c) + 2)) - 1);
        tick       = (pdiv_q >= div_last);
        expire     = tick && (cnt_q == '0) && !do_refresh;
    end

    // configuration shadows in the watchdog domain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_s <= '0;
            rld_s <= RLD_W'(RLD_RESET);
        end else begin
            if (psc_upd) psc_s <= psc_val;
            if (rld_upd) rld_s <= rld_val;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CORE_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CORE_IDLE: if (do_start) st_d = CORE_RUN;
            CORE_RUN,
            CORE_FIRE: st_d = expire ? CORE_FIRE : CORE_RUN;
            default:   st_d = CORE_IDLE;
        endcase
    end

    // prescaler and down-counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pdiv_q <= '0;
            cnt_q  <= RLD_W'(RLD_RESET);
        end else if (st_q == CORE_IDLE) begin
            pdiv_q <= '0;
            if (do_start || do_refresh) cnt_q <= rld_s;
        end else if (do_refresh) begin
            pdiv_q <= '0;
            cnt_q  <= rld_s;
        end else if (tick) begin
            pdiv_q <= '0;
            cnt_q  <= (cnt_q == '0) ? rld_s : cnt_q - 1'b1;
        end else begin
            pdiv_q <= pdiv_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        wd_reset = (st_q == CORE_FIRE);
        running  = (st_q != CORE_IDLE);
    end

endmodule

// File: rtl/kwdg_top.sv
module kwdg_top
    import kwdg_pkg::*;
#(
    parameter int PSC_W     = 3,
    parameter int RLD_W     = 12,
    parameter int RLD_RESET = 4095,
    parameter int MAX_CODE  = 6
) (
    input  logic              bus_clk,
    input  logic              wd_clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              wd_reset
);

    logic             psc_busy, rld_busy, cmd_busy;
    logic [PSC_W-1:0] psc_q, psc_x;
    logic [RLD_W-1:0] rld_q, rld_x;
    logic [CMD_W-1:0] cmd_data, cmd_x;
    logic             psc_load, rld_load, cmd_load;
    logic             psc_upd, rld_upd, cmd_upd;
    logic             lock_open, core_run;

    kwdg_regs #(.PSC_W(PSC_W), .RLD_W(RLD_W), .RLD_RESET(RLD_RESET)) u_regs (
        .clk(bus_clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .psc_busy(psc_busy), .rld_busy(rld_busy), .cmd_busy(cmd_busy),
        .psc_q(psc_q), .rld_q(rld_q),
        .psc_load(psc_load), .rld_load(rld_load), .cmd_load(cmd_load), .cmd_data(cmd_data),
        .lock_open(lock_open)
    );

    kwdg_hs #(.W(PSC_W)) u_hs_psc (
        .src_clk(bus_clk), .dst_clk(wd_clk), .rst_n(rst_n),
        .src_load(psc_load), .src_data(bus_wdata[PSC_W-1:0]), .src_busy(psc_busy),
        .dst_pulse(psc_upd), .dst_data(psc_x)
    );

    kwdg_hs #(.W(RLD_W)) u_hs_rld (
        .src_clk(bus_clk), .dst_clk(wd_clk), .rst_n(rst_n),
        .src_load(rld_load), .src_data(bus_wdata[RLD_W-1:0]), .src_busy(rld_busy),
        .dst_pulse(rld_upd), .dst_data(rld_x)
    );

    kwdg_hs #(.W(CMD_W)) u_hs_cmd (
        .src_clk(bus_clk), .dst_clk(wd_clk), .rst_n(rst_n),
        .src_load(cmd_load), .src_data(cmd_data), .src_busy(cmd_busy),
        .dst_pulse(cmd_upd), .dst_data(cmd_x)
    );

    kwdg_core #(.PSC_W(PSC_W), .RLD_W(RLD_W), .RLD_RESET(RLD_RESET), .MAX_CODE(MAX_CODE)) u_core (
        .clk(wd_clk), .rst_n(rst_n),
        .psc_upd(psc_upd), .psc_val(psc_x),
        .rld_upd(rld_upd), .rld_val(rld_x),
        .cmd_upd(cmd_upd), .cmd_val(cmd_x),
        .wd_reset(wd_reset), .running(core_run)
    );

endmodule

// File: rtl/kwdg_chk.sv
module kwdg_chk
    import kwdg_pkg::*;
#(
    parameter int PSC_W = 3,
    parameter int RLD_W = 12
) (
    input logic              bus_clk,
    input logic              wd_clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              lock_open,
    input logic              psc_busy,
    input logic              rld_busy,
    input logic [PSC_W-1:0]  psc_q,
    input logic [RLD_W-1:0]  rld_q,
    input logic              core_run,
    input logic              wd_reset
);

    AST_LOCKED_PSC_HOLD: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (!lock_open && bus_we && bus_addr == OFS_PSC) |=> $stable(psc_q)); // R3

    AST_LOCKED_RLD_HOLD: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (!lock_open && bus_we && bus_addr == OFS_RLD) |=> $stable(rld_q)); // R3

    AST_BUSY_PSC_HOLD: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (psc_busy && bus_we && bus_addr == OFS_PSC) |=> $stable(psc_q)); // R5

    AST_BUSY_RLD_HOLD: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (rld_busy && bus_we && bus_addr == OFS_RLD) |=> $stable(rld_q)); // R5

    AST_ACCEPT_SETS_BUSY: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (lock_open && !rld_busy && bus_we && bus_addr == OFS_RLD) |=> rld_busy); // R4

    AST_PULSE_SINGLE: assert property (@(posedge wd_clk) disable iff (!rst_n)
        wd_reset |=> !wd_reset); // R9

    AST_RUN_STICKY: assert property (@(posedge wd_clk) disable iff (!rst_n)
        core_run |=> core_run); // R10

    AST_IDLE_NO_PULSE: assert property (@(posedge wd_clk) disable iff (!rst_n)
        !core_run |-> !wd_reset); // R6

endmodule

bind kwdg_top kwdg_chk #(.PSC_W(PSC_W), .RLD_W(RLD_W)) u_chk (
    .bus_clk(bus_clk), .wd_clk(wd_clk), .rst_n(rst_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .lock_open(lock_open),
    .psc_busy(psc_busy), .rld_busy(rld_busy), .psc_q(psc_q), .rld_q(rld_q),
    .core_run(core_run), .wd_reset(wd_reset)
);

// File: tb/kwdg_top_tb.sv
module kwdg_top_tb;

    localparam int CLK_PERIOD  = 10;
    localparam int WCLK_PERIOD = 3 * CLK_PERIOD;
    localparam int VEC_N       = 5;
    // {code[31:29], reload[28:17], expected period[16:0]}
    localparam logic [31:0] VEC [VEC_N] = '{
        {3'd0, 12'd3, 17'd16},
        {3'd1, 12'd2, 17'd24},
        {3'd2, 12'd0, 17'd16},
        {3'd6, 12'd1, 17'd512},
        {3'd7, 12'd0, 17'd256}
    };

    logic        bus_clk = 1'b0, wd_clk = 1'b0, rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wd_reset;

    int checks = 0, errors = 0, pulses = 0, wide = 0;
    logic prev_pulse = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2)  bus_clk = ~bus_clk;
    always #(WCLK_PERIOD/2) wd_clk  = ~wd_clk;

    kwdg_top u_dut (
        .bus_clk(bus_clk), .wd_clk(wd_clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wd_reset(wd_reset)
    );

    always @(negedge wd_clk) begin
        if (wd_reset) pulses++;
        if (wd_reset && prev_pulse) wide++;
        prev_pulse <= wd_reset;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge bus_clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic wait_idle();
        int v;
        for (int i = 0; i < 400; i++) begin
            @(negedge bus_clk);
            rd(5'h0C, v);
            if (v == 0) break;
        end
    endtask

    task automatic wait_w(input int n);
        repeat (n) @(negedge wd_clk);
    endtask

    task automatic measure(output int per);
        per = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge wd_clk);
            if (wd_reset) break;
        end
        for (int i = 1; i < 3000; i++) begin
            @(negedge wd_clk);
            if (wd_reset) begin per = i; break; end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v, base, per;
        repeat (4) @(negedge bus_clk);
        rst_n = 1'b1;
        repeat (2) @(negedge bus_clk);

        // R1 reset state
        rd(5'h04, v); check("R1 prescaler reset", v, 0);
        rd(5'h08, v); check("R1 reload reset", v, 'hFFF);
        rd(5'h0C, v); check("R1 status reset", v, 0);
        check("R1 wd_reset low", int'(wd_reset), 0);
        // R2 key and window read as zero, window ignores writes
        rd(5'h00, v); check("R2 key reads zero", v, 0);
        wr(5'h10, 32'h7); rd(5'h10, v); check("R2 window ignores write", v, 0);

        // R3 locked writes dropped
        wr(5'h04, 32'h5); wr(5'h08, 32'h10);
        rd(5'h04, v); check("R3 locked prescaler", v, 0);
        rd(5'h08, v); check("R3 locked reload", v, 'hFFF);

        // R3 open, R4 busy set, R5 write while busy dropped
        wr(5'h00, 32'h5555);
        @(negedge bus_clk); bus_we = 1'b1; bus_addr = 5'h04; bus_wdata = 32'h2;
        @(negedge bus_clk); bus_wdata = 32'h3;
        @(negedge bus_clk); bus_we = 1'b0;
        rd(5'h0C, v); check("R4 prescaler busy bit", v, 1);
        wait_idle();
        rd(5'h0C, v); check("R4 busy self-clears", v, 0);
        rd(5'h04, v); check("R5 write while busy dropped", v, 2);

        // fast setting for the not-started check
        wr(5'h04, 32'h0); wr(5'h08, 32'h0);
        rd(5'h0C, v); check("R4 both busy bits", v, 3);
        wait_idle();

        // R6/R10 no pulse before start, odd keys ignored
        base = pulses;
        wr(5'h00, 32'h1234); wr(5'h00, 32'hAAAA); wr(5'h00, 32'h0001CCCC);
        wait_w(200);
        check("R6 no pulse before start", pulses - base, 0);

        // start, then vector table for R7
        wr(5'h00, 32'hCCCC);
        for (int k = 0; k < VEC_N; k++) begin
            wr(5'h04, {29'd0, VEC[k][31:29]});
            wr(5'h08, {20'd0, VEC[k][28:17]});
            wait_idle();
            measure(per);
            check($sformatf("R7 period vector %0d", k), per, int'(VEC[k][16:0]));
        end

        // R10 cannot stop; R3 close
        wr(5'h00, 32'h0000); wr(5'h00, 32'h1234); wr(5'h00, 32'hCCCC);
        measure(per);
        check("R10 still running", per, 256);
        wr(5'h04, 32'h1); rd(5'h04, v); check("R3 closed after lock key", v, 7);

        // R8 refresh holds off expiry
        wr(5'h00, 32'h5555);
        wr(5'h04, 32'h0); wr(5'h08, 32'd15);
        wait_idle();
        wr(5'h00, 32'hAAAA);
        wait_w(10);
        base = pulses;
        for (int k = 0; k < 12; k++) begin
            wait_w(25);
            wr(5'h00, 32'hAAAA);
        end
        check("R8 refresh prevents pulse", pulses - base, 0);
        base = pulses;
        wait_w(200);
        check("R8 pulses resume", int'(pulses - base > 0), 1);

        check("R9 single-cycle pulses", wide, 0);

        // R11 reset stops
        @(negedge bus_clk); rst_n = 1'b0;
        repeat (5) @(negedge bus_clk); rst_n = 1'b1;
        repeat (2) @(negedge bus_clk);
        rd(5'h04, v); check("R11 prescaler back to 0", v, 0);
        rd(5'h08, v); check("R11 reload back to FFF", v, 'hFFF);
        base = pulses;
        wait_w(300);
        check("R11 stopped after reset", pulses - base, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule